// File: doc/BRIEF.md
# Charge Pump Gain and Speed-up Controller

This block picks the current-scaling codes for three charge pumps of a frequency synthesizer. Two pumps serve the main phase detector: a proportional pump and an integral pump. The third pump serves the auxiliary detector. A two-bit gain field sets the scale of all three pumps. Its upper bit also switches the integral pump off. Each code is an unsigned count of half-units of the bias current. For example, 3 means 1.5 times the bias current.

The block also decides when the pumps are in speed-up. Speed-up starts on its own after a frequency word has been loaded. It lasts for as many clock cycles as the next strobe pulse stays high. While speed-up is active, the proportional pump moves to its speed-up multiplier. Two control bits change this behaviour:
- A force bit holds speed-up on.
- A block bit keeps speed-up off, and it wins over the force bit.

The block measures each post-load strobe pulse, saturating at a ceiling, so that the strobe width can be compared with the loop filter charge time. Every output is registered and changes one clock after the inputs that cause it are sampled.

Top module: `cp_gain_su_ctrl`

## Requirements
- R1: While reset is low, every code output, `su_active` and `strobe_cycles` read zero.
- R2: `aux_code` is 3 (1.5x) when `gain_sel[0]` is 0 and 1 (0.5x) when it is 1, whatever the speed-up state.
- R3: Outside speed-up, `prop_code` is 6 (3x) when `gain_sel[0]` is 0 and 2 (1x) when it is 1.
- R4: During speed-up, `prop_code` is 30 (15x) when `gain_sel[0]` is 0 and 10 (5x) when it is 1.
- R5: `integ_code` is 72 (36x) for gain 00 and 24 (12x) for gain 01, in both modes. It is 0 whenever `gain_sel[1]` is 1.
- R6: After a `load_done` pulse, the next strobe pulse that is high for N sampled clock edges drives `su_active` high for exactly N cycles. These cycles start one clock after the first high sample.
- R7: A strobe pulse that no `load_done` pulse has preceded since the last speed-up pulse leaves `su_active` low.
- R8: With `su_force` at 1 and `su_block` at 0, `su_active` is 1 one clock later, regardless of strobe.
- R9: With `su_block` at 1, `su_active` is 0 one clock later. This holds even when `su_force` is 1 or an automatic speed-up pulse is running.
- R10: `strobe_cycles` holds the number of high cycles of the last post-load strobe pulse, whether or not speed-up was blocked. The count saturates at WIDTH_MAX (default 200).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gain_sel | input | 2 | Gain field; bit 1 turns the integral pump off |
| su_force | input | 1 | Hold speed-up on |
| su_block | input | 1 | Keep speed-up off (priority over force) |
| load_done | input | 1 | One-cycle pulse at the end of a frequency-word load |
| strobe | input | 1 | Serial-interface load strobe |
| aux_code | output | 7 | Auxiliary pump multiplier, half-units |
| prop_code | output | 7 | Proportional pump multiplier, half-units |
| integ_code | output | 7 | Integral pump multiplier, half-units |
| su_active | output | 1 | Speed-up currently applied |
| strobe_cycles | output | CNT_W (8) | Width of last post-load strobe pulse, saturating |

## Verification
The assertions assume three things about the inputs:
- `load_done` is a single-cycle pulse that never coincides with a high strobe sample.
- Each frequency-word load is followed by at most one strobe pulse before the next load.
- Control inputs change only between clock edges.

The bench drives every input on the falling clock edge. It lowers the strobe before each new `load_done` pulse, and it keeps the force and block bits low while reset is applied. These measures ensure that the properties relating a previous cycle's controls to the present outputs never see pre-reset values.

// File: rtl/cp_ctrl_pkg.sv
package cp_ctrl_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MULT_W = 7;
  typedef logic [MULT_W-1:0] mult_t;

  typedef struct packed {
    mult_t aux;
    mult_t prop;
    mult_t integ;
  } pump_set_t;

  // multipliers in half-units of the bias current
  localparam mult_t AUX_HI  = mult_t'(3);
  localparam mult_t AUX_LO  = mult_t'(1);
  localparam mult_t PROP_HI = mult_t'(6);
  localparam mult_t PROP_LO = mult_t'(2);
  localparam mult_t PSU_HI  = mult_t'(30);
  localparam mult_t PSU_LO  = mult_t'(10);
  localparam mult_t INT_HI  = mult_t'(36 * 2);
  localparam mult_t INT_LO  = mult_t'(12 * 2);

  function automatic pump_set_t pump_lookup(input logic [1:0] g, input logic su);
    pump_set_t r;
    logic low;
    low     = g[0];
    r.aux   = low ? AUX_LO : AUX_HI;
    if (su) r.prop = low ? PSU_LO : PSU_HI;
    else    r.prop = low ? PROP_LO : PROP_HI;
    if (g[1]) r.integ = '0;
    else      r.integ = low ? INT_LO : INT_HI;
    return r;
  endfunction
endpackage

// File: rtl/cp_gain_table.sv
module cp_gain_table
  import cp_ctrl_pkg::*;
(
  input  logic [1:0] gain_sel,
  input  logic       su_mode,
  output pump_set_t  pumps
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb pumps = pump_lookup(gain_sel, su_mode);
endmodule

// File: rtl/cp_su_timer.sv
module cp_su_timer #(
  parameter  int WIDTH_MAX = 200,
  localparam int CNT_W     = $clog2(WIDTH_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_done,
  input  logic             strobe,
  output logic             pulse_next,
  output logic [CNT_W-1:0] width_q
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIDTH_MAX);

  logic armed_q, pulse_q;
  logic su_start;   // first sampled high strobe cycle after a load
  logic at_ceiling;

  assign pulse_next = strobe & (armed_q | pulse_q);
  assign su_start   = pulse_next & ~pulse_q;
  assign at_ceiling = (width_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
      width_q <= '0;
    end else begin
      pulse_q <= pulse_next;
      if (load_done)     armed_q <= 1'b1;
      else if (su_start) armed_q <= 1'b0;
      if (su_start)                     width_q <= CNT_W'(1);
      else if (pulse_next && !at_ceiling) width_q <= width_q + 1'b1;
    end
  end

  // R10: count never passes its ceiling
  p_width_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    width_q <= CNT_MAX);

  // R10: a continuing pulse adds one per cycle below the ceiling
  p_width_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q && pulse_next && !at_ceiling |=> width_q == $past(width_q) + 1'b1);

  // R10: outside a pulse the measured width is held
  p_width_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !pulse_next |=> $stable(width_q));

  // R7: an unarmed idle timer cannot begin a pulse
  p_no_unarmed_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !armed_q && !pulse_q |=> !pulse_q);
endmodule

// File: rtl/cp_gain_su_ctrl.sv
module cp_gain_su_ctrl
  import cp_ctrl_pkg::*;
#(
  parameter  int WIDTH_MAX = 200,
  localparam int CNT_W     = $clog2(WIDTH_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       gain_sel,
  input  logic             su_force,
  input  logic             su_block,
  input  logic             load_done,
  input  logic             strobe,
  output logic [6:0]       aux_code,
  output logic [6:0]       prop_code,
  output logic [6:0]       integ_code,
  output logic             su_active,
  output logic [CNT_W-1:0] strobe_cycles
);
  timeunit 1ns;
  timeprecision 1ps;

  logic      pulse_next;
  logic      su_d;
  pump_set_t pumps_d;

  cp_su_timer #(.WIDTH_MAX(WIDTH_MAX)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_done  (load_done),
    .strobe     (strobe),
    .pulse_next (pulse_next),
    .width_q    (strobe_cycles)
  );

  // block wins over force and over the automatic pulse
  assign su_d = ~su_block & (su_force | pulse_next);

  cp_gain_table u_table (
    .gain_sel (gain_sel),
    .su_mode  (su_d),
    .pumps    (pumps_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      su_active  <= 1'b0;
      aux_code   <= '0;
      prop_code  <= '0;
      integ_code <= '0;
    end else begin
      su_active  <= su_d;
      aux_code   <= pumps_d.aux;
      prop_code  <= pumps_d.prop;
      integ_code <= pumps_d.integ;
    end
  end

  // R9
  p_block_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(su_block) |-> !su_active);

  // R8
  p_force_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(su_force && !su_block) |-> su_active);

  // R5
  p_integ_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(gain_sel[1]) |-> integ_code == '0);

  // R4
  p_prop_su_r4: assert property (@(posedge clk) disable iff (!rst_n)
    su_active |-> (prop_code == PSU_HI) || (prop_code == PSU_LO));

  // R2
  p_aux_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (aux_code == AUX_HI) || (aux_code == AUX_LO));
endmodule

// File: tb/test_cp_gain_su_ctrl.sv
module test_cp_gain_su_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WMAX = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] gain_sel = 2'b00;
  logic       su_force = 1'b0, su_block = 1'b0, load_done = 1'b0, strobe = 1'b0;
  logic [6:0] aux_code, prop_code, integ_code;
  logic       su_active;
  logic [7:0] strobe_cycles;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cp_gain_su_ctrl #(.WIDTH_MAX(WMAX)) i_cp_gain_su_ctrl (
    .clk(clk), .rst_n(rst_n), .gain_sel(gain_sel), .su_force(su_force),
    .su_block(su_block), .load_done(load_done), .strobe(strobe),
    .aux_code(aux_code), .prop_code(prop_code), .integ_code(integ_code),
    .su_active(su_active), .strobe_cycles(strobe_cycles)
  );

  // {gain, force, block, expected su}
  localparam logic [4:0] VEC [10] = '{
    5'b00_0_0_0, 5'b01_0_0_0, 5'b10_0_0_0, 5'b11_0_0_0,
    5'b00_1_0_1, 5'b01_1_0_1, 5'b10_1_0_1, 5'b11_1_0_1,
    5'b00_1_1_0, 5'b11_0_1_0
  };

  function automatic int unit_of(input logic [1:0] g);
    return g[0] ? 1 : 3;
  endfunction
  function automatic int want_prop(input logic [1:0] g, input logic su);
    return unit_of(g) * (su ? 10 : 2);
  endfunction
  function automatic int want_integ(input logic [1:0] g);
    return g[1] ? 0 : unit_of(g) * 24;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // runs load then an N-cycle strobe; returns cycles with su_active high
  task automatic load_and_strobe(input int n, output int su_cnt);
    su_cnt = 0;
    load_done = 1'b1;
    step();
    load_done = 1'b0;
    step();
    strobe = 1'b1;
    for (int i = 0; i < n; i++) begin
      step();
      if (su_active) su_cnt++;
    end
    strobe = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      if (su_active) su_cnt++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int cnt;
    @(negedge clk);
    step();
    // R1: reset state
    check(su_active == 1'b0 && aux_code == 0 && prop_code == 0 && integ_code == 0,
          "R1 codes", int'(aux_code) + int'(prop_code) + int'(integ_code), 0);
    check(strobe_cycles == 0, "R1 width", int'(strobe_cycles), 0);
    rst_n = 1'b1;
    step();

    // table walk: R2 R3 R4 R5 R8 R9
    for (int v = 0; v < 10; v++) begin
      gain_sel = VEC[v][4:3];
      su_force = VEC[v][2];
      su_block = VEC[v][1];
      step();
      check(su_active == VEC[v][0], "R8/R9 su", int'(su_active), int'(VEC[v][0]));
      check(int'(aux_code) == unit_of(gain_sel), "R2 aux", int'(aux_code), unit_of(gain_sel));
      check(int'(prop_code) == want_prop(gain_sel, VEC[v][0]), "R3/R4 prop",
            int'(prop_code), want_prop(gain_sel, VEC[v][0]));
      check(int'(integ_code) == want_integ(gain_sel), "R5 integ",
            int'(integ_code), want_integ(gain_sel));
    end
    su_force = 1'b0;
    su_block = 1'b0;
    gain_sel = 2'b00;
    step();

    // R6: automatic speed-up lasts exactly the strobe width
    load_and_strobe(5, cnt);
    check(cnt == 5, "R6 su cycles", cnt, 5);
    check(strobe_cycles == 5, "R10 width", int'(strobe_cycles), 5);

    // R4: speed-up value seen mid-pulse at gain 01
    gain_sel = 2'b01;
    load_done = 1'b1;
    step();
    load_done = 1'b0;
    strobe = 1'b1;
    step();
    step();
    check(su_active && prop_code == 10, "R4 prop mid-pulse", int'(prop_code), 10);
    check(integ_code == 24, "R5 integ in speed-up", int'(integ_code), 24);
    strobe = 1'b0;
    step();
    check(!su_active && prop_code == 2, "R3 prop after pulse", int'(prop_code), 2);

    // R7: strobe with no preceding load
    cnt = 0;
    strobe = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      if (su_active) cnt++;
    end
    strobe = 1'b0;
    step();
    check(cnt == 0, "R7 unarmed strobe", cnt, 0);
    check(strobe_cycles == 2, "R7 width kept", int'(strobe_cycles), 2);

    // R9: block suppresses automatic pulse; R10 still measures it
    su_block = 1'b1;
    load_and_strobe(3, cnt);
    check(cnt == 0, "R9 blocked pulse", cnt, 0);
    check(strobe_cycles == 3, "R10 width when blocked", int'(strobe_cycles), 3);
    su_block = 1'b0;

    // R8: force holds regardless of strobe
    su_force = 1'b1;
    strobe = 1'b1;
    step();
    strobe = 1'b0;
    step();
    step();
    check(su_active == 1'b1, "R8 force held", int'(su_active), 1);
    su_force = 1'b0;
    step();
    check(su_active == 1'b0, "R8 force released", int'(su_active), 0);

    // R10: saturation
    load_and_strobe(WMAX + 10, cnt);
    check(cnt == WMAX + 10, "R6 long pulse", cnt, WMAX + 10);
    check(int'(strobe_cycles) == WMAX, "R10 saturation", int'(strobe_cycles), WMAX);

    // R1: reset again clears
    rst_n = 1'b0;
    step();
    check(strobe_cycles == 0 && aux_code == 0, "R1 re-reset",
          int'(strobe_cycles) + int'(aux_code), 0);

    done = 1'b1;
    finish_run();
  end
endmodule